// File: doc/BRIEF.md
# Command Status Record Ring Writer

This block sits behind a command execution engine and turns each finished command into a fixed-length status record. It writes the record, one 32-bit word per cycle, into a circular ring held in a memory. The block drives only the write port of that memory. Software reads the ring through the other port. A record opens with a two-word header. The header carries the number of the command that produced it, the execution time in microseconds, an execution status code, and a timestamp taken when the record is written. Payload words follow the header.

The engine pulses a start strobe with the command number when execution begins. It pulses a done strobe with the status code and payload words when execution ends. The time between the two is measured by counting microsecond ticks, so queueing time before the start is not included. A head pointer gives the slot that the next record will occupy.

The top four bits of each record's last word hold a wrap-generation count. The count is 1 during the first pass around the ring and steps each time the head returns to slot 0. Software can therefore tell fresh entries from stale ones without reading the head pointer.

Top module: `stsring_writer`

## Requirements
- R1: Bits [15:0] of record word 0 equal the command number presented with the most recent start pulse before the record was accepted.
- R2: Bits [25:16] of word 0 equal the number of cycles with the microsecond tick high, counted after the start-pulse cycle and before the accepted done cycle. The value saturates at 1023.
- R3: Bits [27:26] of word 0 carry the status code given with done (0 success, 1 blocked, 2 failed, 3 resource blocked). Bits [31:28] of word 0 are 0.
- R4: When the status code is 2 or 3, every payload word (words 2 to 25) is written as 0, except the generation count bits of word 25.
- R5: Word 1 equals the timestamp input value in the cycle that word 0 is written.
- R6: A record is 26 words long. It is written to consecutive addresses slot*26+0 to slot*26+25, one word per cycle, starting the cycle after the done is accepted.
- R7: Bits [31:28] of word 25 hold the generation count. The count is 1 during the first pass through the ring, increases by one each time the head wraps to slot 0, and goes from 15 back to 0.
- R8: The head pointer resets to 0. It advances by one slot at the end of each record, and from the last slot it returns to 0.
- R9: Ready is low from the cycle after acceptance through the last word write. A done presented while ready is low is not taken until ready returns high.
- R10: For status codes 0 and 1, payload words 2 to 25 carry the input payload words unchanged, except bits [31:28] of word 25.
- R11: After reset, ready is high, the write enable is low and the head is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_start_i | input | 1 | Command execution begins (one-cycle pulse) |
| cmd_num_i | input | 16 | Command number, sampled with cmd_start_i |
| cmd_done_i | input | 1 | Command finished; held until accepted |
| cmd_st_i | input | 2 | Execution status code |
| cmd_pay_i | input | 768 | 24 payload words; word k at bits [32k+31:32k] |
| done_ready_o | output | 1 | Block can accept a done |
| ts_i | input | 32 | Free-running timestamp |
| us_tick_i | input | 1 | One-microsecond tick |
| ring_we_o | output | 1 | Ring write enable |
| ring_addr_o | output | 8 | Ring word address |
| ring_wdata_o | output | 32 | Ring write data |
| head_o | output | 3 | Slot of the next record |

## Verification
On every cycle the bound checker checks the following: word 0 has zero reserved bits, failed and resource-blocked records have zero payload, write addresses step by one inside a record, a write burst starts only on an accepted done, ready is low during writes, and the head moves only by one slot and only after a record's last word. The execution-time count, its saturation, the timestamp sample, the number echo and the generation-count sequence across sixteen ring passes depend on values presented many cycles earlier. Only the bench scenarios show these, by comparing each slot with the values the bench sent.

// File: rtl/stsring_pkg.sv
package stsring_pkg;

   typedef enum logic [1:0] {
      ST_OK          = 2'd0,
      ST_BLOCKED     = 2'd1,
      ST_FAILED      = 2'd2,
      ST_RES_BLOCKED = 2'd3
   } exec_st_e;

   // first header word layout; positions are decoded by the consumer
   typedef struct packed {
      logic [3:0]  rsvd;
      exec_st_e    st;
      logic [9:0]  etime;
      logic [15:0] num;
   } hdr_w0_t;

   function automatic logic payload_valid(input logic [1:0] st);
      return ~st[1];
   endfunction

endpackage

// File: rtl/stsring_exec_timer.sv
module stsring_exec_timer #(
   parameter int TIME_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              tick_i,
   output logic [TIME_W-1:0] time_o
);
   logic [TIME_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != {TIME_W{1'b1}})) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign time_o = cnt_q;
endmodule

// File: rtl/stsring_ring_ptr.sv
module stsring_ring_ptr #(
   parameter int SLOTS  = 8,
   parameter int LOOP_W = 4,
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   output logic [SLOT_W-1:0] head_o,
   output logic [LOOP_W-1:0] loop_o
);
   logic [SLOT_W-1:0] head_q, head_nx;
   logic [LOOP_W-1:0] loop_q;
   logic              wrap;

   generate
      if ((SLOTS & (SLOTS - 1)) == 0) begin : g_pow2
         assign wrap    = &head_q;
         assign head_nx = head_q + 1'b1;
      end else begin : g_mod
         assign wrap    = (head_q == SLOT_W'(SLOTS - 1));
         assign head_nx = wrap ? '0 : head_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         loop_q <= LOOP_W'(1);
      end else if (adv_i) begin
         head_q <= head_nx;
         if (wrap) loop_q <= loop_q + 1'b1;
      end
   end

   assign head_o = head_q;
   assign loop_o = loop_q;
endmodule

// File: rtl/stsring_word_sel.sv
module stsring_word_sel #(
   parameter int DW        = 32,
   parameter int REC_WORDS = 26,
   parameter int LOOP_W    = 4,
   parameter int IDX_W     = 5,
   localparam int PAY_WORDS = REC_WORDS - 2
) (
   input  logic [IDX_W-1:0]        idx_i,
   input  logic [DW-1:0]           hdr_i,
   input  logic [DW-1:0]           ts_i,
   input  logic [PAY_WORDS*DW-1:0] pay_i,
   input  logic [LOOP_W-1:0]       loop_i,
   output logic [DW-1:0]           word_o
);
   logic [DW-1:0]    pay_w [PAY_WORDS];
   logic [IDX_W-1:0] pidx;

   generate
      for (genvar k = 0; k < PAY_WORDS; k++) begin : g_unpack
         assign pay_w[k] = pay_i[k*DW +: DW];
      end
   endgenerate

   always_comb begin
      pidx = idx_i - IDX_W'(2);
      if (idx_i == '0)           word_o = hdr_i;
      else if (idx_i == IDX_W'(1)) word_o = ts_i;
      else                       word_o = pay_w[pidx];
      if (idx_i == IDX_W'(REC_WORDS - 1))
         word_o[DW-1 -: LOOP_W] = loop_i;
   end
endmodule

// File: rtl/stsring_writer.sv
module stsring_writer
   import stsring_pkg::*;
#(
   parameter int DW        = 32,
   parameter int REC_WORDS = 26,
   parameter int SLOTS     = 8,
   parameter int NUM_W     = 16,
   parameter int TIME_W    = 10,
   parameter int LOOP_W    = 4,
   parameter int TS_W      = 32,
   localparam int PAY_WORDS = REC_WORDS - 2,
   localparam int AW        = $clog2(SLOTS * REC_WORDS),
   localparam int IDX_W     = $clog2(REC_WORDS),
   localparam int SLOT_W    = $clog2(SLOTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_start_i,
   input  logic [NUM_W-1:0]        cmd_num_i,
   input  logic                    cmd_done_i,
   input  logic [1:0]              cmd_st_i,
   input  logic [PAY_WORDS*DW-1:0] cmd_pay_i,
   output logic                    done_ready_o,
   input  logic [TS_W-1:0]         ts_i,
   input  logic                    us_tick_i,
   output logic                    ring_we_o,
   output logic [AW-1:0]           ring_addr_o,
   output logic [DW-1:0]           ring_wdata_o,
   output logic [SLOT_W-1:0]       head_o
);
   // elaboration checks
   generate
      if (DW != 32)       begin : g_bad_dw   $error("DW must be 32");        end
      if (NUM_W != 16)    begin : g_bad_num  $error("NUM_W must be 16");     end
      if (TIME_W != 10)   begin : g_bad_time $error("TIME_W must be 10");    end
      if (TS_W != DW)     begin : g_bad_ts   $error("TS_W must equal DW");   end
      if (REC_WORDS < 3)  begin : g_bad_rec  $error("REC_WORDS too small");  end
      if (SLOTS < 2)      begin : g_bad_slot $error("SLOTS must be >= 2");   end
      if (LOOP_W > 4)     begin : g_bad_loop $error("LOOP_W must be <= 4");  end
   endgenerate

   logic [NUM_W-1:0]        num_q;
   logic [TIME_W-1:0]       etime;
   logic                    busy_q;
   logic [IDX_W-1:0]        idx_q;
   hdr_w0_t                 hdr_q;
   logic [PAY_WORDS*DW-1:0] pay_q;
   logic [DW-1:0]           ts_q;
   logic [LOOP_W-1:0]       loop;
   logic [SLOT_W-1:0]       head;
   logic                    accept, last_word;

   assign accept    = cmd_done_i & ~busy_q;
   assign last_word = busy_q & (idx_q == IDX_W'(REC_WORDS - 1));

   stsring_exec_timer #(.TIME_W(TIME_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (cmd_start_i),
      .tick_i  (us_tick_i),
      .time_o  (etime)
   );

   stsring_ring_ptr #(.SLOTS(SLOTS), .LOOP_W(LOOP_W), .SLOT_W(SLOT_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (last_word),
      .head_o (head),
      .loop_o (loop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q <= '0;
      end else if (cmd_start_i) begin
         num_q <= cmd_num_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         hdr_q  <= '0;
         pay_q  <= '0;
         ts_q   <= '0;
      end else if (accept) begin
         busy_q     <= 1'b1;
         idx_q      <= '0;
         hdr_q.rsvd <= '0;
         hdr_q.st   <= exec_st_e'(cmd_st_i);
         hdr_q.etime <= etime;
         hdr_q.num  <= num_q;
         pay_q      <= payload_valid(cmd_st_i) ? cmd_pay_i : '0;
      end else if (busy_q) begin
         if (idx_q == '0) ts_q <= ts_i;
         if (last_word) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   stsring_word_sel #(
      .DW(DW), .REC_WORDS(REC_WORDS), .LOOP_W(LOOP_W), .IDX_W(IDX_W)
   ) u_sel (
      .idx_i  (idx_q),
      .hdr_i  (hdr_q),
      .ts_i   ((idx_q == '0) ? ts_i : ts_q),
      .pay_i  (pay_q),
      .loop_i (loop),
      .word_o (ring_wdata_o)
   );

   assign done_ready_o = ~busy_q;
   assign ring_we_o    = busy_q;
   assign ring_addr_o  = AW'(head) * AW'(REC_WORDS) + AW'(idx_q);
   assign head_o       = head;
endmodule

// File: rtl/stsring_writer_chk.sv
module stsring_writer_chk #(
   parameter int DW        = 32,
   parameter int REC_WORDS = 26,
   parameter int AW        = 8,
   parameter int SLOTS     = 8,
   parameter int SLOT_W    = 3,
   localparam int CI_W     = $clog2(REC_WORDS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done_i,
   input logic              ready_i,
   input logic              we_i,
   input logic [AW-1:0]     addr_i,
   input logic [DW-1:0]     wdata_i,
   input logic [SLOT_W-1:0] head_i
);
   logic [CI_W-1:0] ck_idx;
   logic [1:0]      ck_st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_idx <= '0;
         ck_st  <= '0;
      end else if (we_i) begin
         if (ck_idx == '0) ck_st <= wdata_i[27:26];
         ck_idx <= (ck_idx == CI_W'(REC_WORDS - 1)) ? '0 : ck_idx + 1'b1;
      end
   end

   p_hdr_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && ck_idx == '0) |-> (wdata_i[31:28] == 4'd0));

   p_fail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && ck_idx >= CI_W'(2) && ck_st[1]) |-> (wdata_i[27:0] == 28'd0));

   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && $past(we_i) && ck_idx != '0) |-> (addr_i == $past(addr_i) + 1'b1));

   p_burst_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_i) |-> $past(done_i && ready_i));

   p_ready_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> !ready_i);

   p_head_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (head_i != $past(head_i)) |->
         (head_i == (($past(head_i) == SLOT_W'(SLOTS - 1)) ? '0 : $past(head_i) + 1'b1)));

   p_head_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (head_i != $past(head_i)) |-> $past(we_i && ck_idx == CI_W'(REC_WORDS - 1)));
endmodule

bind stsring_writer stsring_writer_chk #(
   .DW(DW), .REC_WORDS(REC_WORDS), .AW(AW), .SLOTS(SLOTS), .SLOT_W(SLOT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .done_i  (cmd_done_i),
   .ready_i (done_ready_o),
   .we_i    (ring_we_o),
   .addr_i  (ring_addr_o),
   .wdata_i (ring_wdata_o),
   .head_i  (head_o)
);

// File: tb/sim_stsring_writer.sv
`timescale 1ns/1ps
module sim_stsring_writer;
   localparam int REC   = 26;
   localparam int SLOTS = 8;
   localparam int PAYW  = REC - 2;
   localparam int DEPTH = SLOTS * REC;

   logic              clk = 0;
   logic              rst_n = 0;
   logic              start = 0;
   logic [15:0]       snum = '0;
   logic              done = 0;
   logic [1:0]        dst = '0;
   logic [PAYW*32-1:0] pay = '0;
   logic              ready;
   logic [31:0]       ts = '0;
   logic              tick = 0;
   logic              we;
   logic [7:0]        addr;
   logic [31:0]       wdata;
   logic [2:0]        head;

   stsring_writer u0 (
      .clk(clk), .rst_n(rst_n), .cmd_start_i(start), .cmd_num_i(snum),
      .cmd_done_i(done), .cmd_st_i(dst), .cmd_pay_i(pay), .done_ready_o(ready),
      .ts_i(ts), .us_tick_i(tick), .ring_we_o(we), .ring_addr_o(addr),
      .ring_wdata_o(wdata), .head_o(head)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 0, held_seen = 0, saw_loop0 = 0, saw_loop15 = 0;
   logic [31:0] bmem [DEPTH];
   int          bcyc [DEPTH];
   logic [31:0] bts  [SLOTS];
   logic [15:0] e_num  [SLOTS];
   logic [1:0]  e_st   [SLOTS];
   int          e_et   [SLOTS];
   logic [31:0] e_seed [SLOTS];
   logic [3:0]  e_loop [SLOTS];
   int          e_acc  [SLOTS];
   int          exp_head = 0;
   logic [3:0]  exp_loop = 4'd1;

   initial forever begin @(posedge clk); cyc++; #1 ts = ts + 32'd7; end

   initial forever begin
      @(negedge clk);
      if (rst_n && we) begin
         bmem[int'(addr)] = wdata;
         bcyc[int'(addr)] = cyc;
         if (int'(addr) % REC == 0) bts[int'(addr) / REC] = ts;
      end
   end

   function automatic logic [31:0] pw(input logic [31:0] seed, input int j);
      return seed ^ (32'h9E37_79B9 * (j + 1));
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [15:0] num, input logic [1:0] st, input int ticks,
                        input logic [31:0] seed);
      @(posedge clk); #1;
      start = 1; snum = num;
      @(posedge clk); #1;
      start = 0;
      if (ticks > 0) begin
         tick = 1;
         repeat (ticks) @(posedge clk);
         #1 tick = 0;
      end
      done = 1; dst = st;
      for (int j = 0; j < PAYW; j++) pay[j*32 +: 32] = pw(seed, j);
      forever begin
         @(negedge clk);
         if (ready) break;
         held_seen = 1;
      end
      e_num[exp_head]  = num;
      e_st[exp_head]   = st;
      e_et[exp_head]   = (ticks > 1023) ? 1023 : ticks;
      e_seed[exp_head] = seed;
      e_loop[exp_head] = exp_loop;
      e_acc[exp_head]  = cyc;
      if (exp_head == SLOTS - 1) begin exp_head = 0; exp_loop = exp_loop + 1; end
      else exp_head = exp_head + 1;
      @(posedge clk); #1;
      done = 0;
   endtask

   task automatic wait_idle();
      forever begin
         @(negedge clk);
         if (ready) break;
      end
   endtask

   task automatic verify(input int slot);
      int base = slot * REC;
      logic [31:0] w0 = bmem[base];
      int bad = 0;
      logic [31:0] e;
      check("R1 number echo", {16'd0, w0[15:0]}, {16'd0, e_num[slot]});
      check("R2 exec time", {22'd0, w0[25:16]}, 32'(e_et[slot]));
      check("R3 status+rsvd", {28'd0, w0[31:26]}, {28'd0, 2'b00, e_st[slot]});
      check("R5 timestamp", bmem[base+1], bts[slot]);
      for (int j = 0; j < PAYW; j++) begin
         e = e_st[slot][1] ? 32'd0 : pw(e_seed[slot], j);
         if (j == PAYW - 1) e[31:28] = e_loop[slot];
         check(e_st[slot][1] ? "R4 payload zero" : "R10 payload", bmem[base+2+j], e);
      end
      check("R7 gen count", {28'd0, bmem[base+REC-1][31:28]}, {28'd0, e_loop[slot]});
      if (bmem[base+REC-1][31:28] == 4'd0)  saw_loop0 = 1;
      if (bmem[base+REC-1][31:28] == 4'd15) saw_loop15 = 1;
      for (int j = 0; j < REC; j++) if (bcyc[base+j] != e_acc[slot] + 1 + j) bad++;
      check("R6 word timing", 32'(bad), 32'd0);
      check("R8 head", {29'd0, head}, 32'(exp_head));
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 ready in reset", {31'd0, ready}, 32'd1);
      check("R11 we in reset", {31'd0, we}, 32'd0);
      check("R11 head in reset", {29'd0, head}, 32'd0);
      @(posedge clk); #1 rst_n = 1;
      @(negedge clk);
      check("R11 ready after reset", {31'd0, ready}, 32'd1);
   endtask

   task automatic t_success();
      int s = exp_head;
      issue(16'h1234, 2'd0, 5, 32'hC0DE_0001);
      wait_idle();
      verify(s);
   endtask

   task automatic t_blocked();
      int s = exp_head;
      issue(16'hBEEF, 2'd1, 0, 32'hF00D_0002);
      wait_idle();
      verify(s);
   endtask

   task automatic t_failed();
      int s = exp_head;
      issue(16'h0F0F, 2'd2, 3, 32'hFFFF_FFFF);
      wait_idle();
      verify(s);
      s = exp_head;
      issue(16'hFFFF, 2'd3, 1, 32'hA5A5_5A5A);
      wait_idle();
      verify(s);
   endtask

   task automatic t_saturate();
      int s = exp_head;
      issue(16'h0042, 2'd0, 1100, 32'h1357_9BDF);
      wait_idle();
      verify(s);
      s = exp_head;
      issue(16'h0043, 2'd0, 1023, 32'h2468_ACE0);
      wait_idle();
      verify(s);
   endtask

   task automatic t_backpressure();
      int sa = exp_head;
      int sb;
      held_seen = 0;
      issue(16'h0AAA, 2'd0, 2, 32'h1111_2222);
      sb = exp_head;
      issue(16'h0BBB, 2'd1, 2, 32'h3333_4444);
      check("R9 done held off", {31'd0, held_seen}, 32'd1);
      wait_idle();
      verify(sa);
      verify(sb);
   endtask

   task automatic t_wrap();
      for (int r = 0; r < 130; r++) begin
         int s = exp_head;
         issue(16'(r * 3 + 5), 2'(r % 4), r % 3, 32'h5000_0000 + 32'(r));
         wait_idle();
         verify(s);
      end
      check("R7 gen count reached 15", {31'd0, saw_loop15}, 32'd1);
      check("R7 gen count wrapped to 0", {31'd0, saw_loop0}, 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_success();
      t_blocked();
      t_failed();
      t_saturate();
      t_backpressure();
      t_wrap();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule